// File: doc/BRIEF.md
# DSI Read-Response Parser

After a bus turnaround, a DSI peripheral sends bytes back to the host. This block takes those bytes one at a time and works out what each response is. A response starts with a trigger byte, which is either an acknowledge, an escape trigger or an unrecognised value. An acknowledge may be followed by a packet. The block checks the packet header with its Hamming ECC and corrects a single-bit error. It then decodes the data type and turns the response into 32-bit little-endian words in a read FIFO. The FIFO count shows how many words are waiting.

Software drains the FIFO one word per pop. The first word is always the trigger byte. For a packet, the corrected header word comes next, followed by any long-read payload. The block also keeps these per-response indications:
- the kind of trigger;
- the 16-bit error report of an acknowledge-with-error packet;
- a flag for a corrected ECC error;
- a flag for an uncorrectable ECC error;
- a protocol-error flag;
- overflow and underflow flags.

All of these are cleared when the next trigger byte arrives.

Top module: `dsi_rsp_parser`

## Requirements
- R1: After reset, `rd_count` is 0, `rd_data` is 0, `trig_kind` is 0 (none), `err_rpt` is 0 and every flag is low.
- R2: A byte with `rx_first` high is a trigger byte. It is pushed as the word `{24'h0, byte}`. `trig_kind` becomes 1 for 0x84 (acknowledge), 2 for 0x87 (escape) and 3 for any other value. Only after 0x84, and only when the byte is not marked last, are the following bytes parsed as a packet. After any other trigger the rest of the transmission pushes nothing.
- R3: A packet header is four bytes: DI, D0, D1 and ECC. The data type is DI bits 5:0. Data type 0x02 (acknowledge with error report) pushes the header word and sets `err_rpt` to `{D1, D0}`.
- R4: Data type 0x21 (1-byte short read) and data type 0x22 (2-byte short read) each push exactly one word, `{8'h00, D1, D0, DI}`.
- R5: Data type 0x1A (generic long read) and data type 0x1C (DCS long read) push the header word. The byte count L is `{D1, D0}`. Then ceil(L/4) payload words follow. The earliest byte goes in bits 7:0, and unused upper bytes of the final word are zero. The two checksum bytes after the payload are discarded.
- R6: Any other data type sets `proto_err` and pushes no word for that packet.
- R7: A header whose ECC syndrome matches a single flipped bit is corrected before it is decoded and pushed, and `ecc_fixed` is set. The ECC is the standard DSI 6-bit Hamming code over the 24 header bits, with ECC bits 7:6 equal to zero.
- R8: A header with an uncorrectable ECC syndrome sets `ecc_multi` and pushes nothing for that packet.
- R9: `rd_data` shows the oldest word. A cycle with `rd_pop` high removes that word, and `rd_count` drops by one at that clock edge.
- R10: Popping while the FIFO is empty leaves `rd_count` at 0, keeps `rd_data` at 0 and sets `udf`.
- R11: A word pushed while `DEPTH` words are waiting is dropped and sets `ovf`. `rd_count` never exceeds `DEPTH`.
- R12: A new trigger byte clears `err_rpt`, `ecc_fixed`, `ecc_multi`, `proto_err`, `ovf` and `udf` before any new events are recorded.
- R13: If `rx_last` arrives before a long packet's header, payload and two checksum bytes are complete, `proto_err` is set and any partially filled payload word is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present |
| rx_byte | input | 8 | Received byte |
| rx_first | input | 1 | The byte is the trigger byte that opens a response |
| rx_last | input | 1 | The byte ends the transmission |
| rd_pop | input | 1 | Remove the oldest word from the read FIFO |
| rd_data | output | 32 | Oldest word, or 0 when the FIFO is empty |
| rd_count | output | CNT_W (5) | Number of words waiting |
| trig_kind | output | 2 | 0 none, 1 acknowledge, 2 escape, 3 unknown |
| err_rpt | output | 16 | Error field of the last acknowledge-with-error packet |
| ecc_fixed | output | 1 | A single-bit header error was corrected |
| ecc_multi | output | 1 | An uncorrectable header error was seen |
| proto_err | output | 1 | Unknown data type, or a truncated long packet |
| ovf | output | 1 | A word was dropped because the FIFO was full |
| udf | output | 1 | A pop was made while the FIFO was empty |

## Verification
Every result is due at the rising edge that samples the byte completing it. A trigger word, a header word or a full payload word is counted in `rd_count` one edge after its final byte is presented, and every flag and `err_rpt` change at that same edge. A pop updates `rd_count` and `rd_data` at the edge where `rd_pop` is seen. The bench therefore drives every byte and pop on a falling edge and compares outputs on the next falling edge. Each header ECC byte is computed in the bench from the six parity masks, so correction and rejection are judged against an independent encoder.

// File: rtl/dsi_rsp_pkg.sv
package dsi_rsp_pkg;

  localparam logic [7:0] TRIG_ACK_CODE = 8'h84;
  localparam logic [7:0] TRIG_ESC_CODE = 8'h87;

  localparam logic [5:0] DT_ACK_ERR  = 6'h02;
  localparam logic [5:0] DT_GEN_LONG = 6'h1A;
  localparam logic [5:0] DT_DCS_LONG = 6'h1C;
  localparam logic [5:0] DT_SHORT1   = 6'h21;
  localparam logic [5:0] DT_SHORT2   = 6'h22;

  localparam int LEN_W = 16;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_ACK  = 2'd1,
    TRIG_ESC  = 2'd2,
    TRIG_UNK  = 2'd3
  } trig_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_CSUM,
    ST_DRAIN
  } pst_e;

endpackage

// File: rtl/dsi_rsp_ecc.sv
module dsi_rsp_ecc (
  input  logic [23:0] data_in,
  input  logic [7:0]  ecc_in,
  output logic [23:0] data_out,
  output logic        single_fix,
  output logic        multi_err
);

  // Parity-check column of each header bit (bit p set: bit feeds parity p)
  function automatic logic [5:0] bit_code(input int idx);
    case (idx)
      0:  bit_code = 6'h07;
      1:  bit_code = 6'h0B;
      2:  bit_code = 6'h0D;
      3:  bit_code = 6'h0E;
      4:  bit_code = 6'h13;
      5:  bit_code = 6'h15;
      6:  bit_code = 6'h16;
      7:  bit_code = 6'h19;
      8:  bit_code = 6'h1A;
      9:  bit_code = 6'h1C;
      10: bit_code = 6'h23;
      11: bit_code = 6'h25;
      12: bit_code = 6'h26;
      13: bit_code = 6'h29;
      14: bit_code = 6'h2A;
      15: bit_code = 6'h2C;
      16: bit_code = 6'h31;
      17: bit_code = 6'h32;
      18: bit_code = 6'h34;
      19: bit_code = 6'h38;
      20: bit_code = 6'h1F;
      21: bit_code = 6'h2F;
      22: bit_code = 6'h37;
      23: bit_code = 6'h3B;
      default: bit_code = 6'h00;
    endcase
  endfunction

  logic [5:0] calc;
  logic [7:0] synd;
  logic       hit;

  always_comb begin
    calc = 6'h00;
    for (int i = 0; i < 24; i++) begin
      if (data_in[i]) calc = calc ^ bit_code(i);
    end
    synd     = {2'b00, calc} ^ ecc_in;
    data_out = data_in;
    hit      = 1'b0;
    for (int i = 0; i < 24; i++) begin
      if (synd == {2'b00, bit_code(i)}) begin
        data_out[i] = ~data_in[i];
        hit         = 1'b1;
      end
    end
    if ($onehot(synd)) hit = 1'b1;
    single_fix = (synd != 8'h00) && hit;
    multi_err  = (synd != 8'h00) && !hit;
  end

endmodule

// File: rtl/dsi_rsp_fifo.sv
module dsi_rsp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     wdata,
  input  logic             pop,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) ptr_inc = '0;
    else                        ptr_inc = p + 1'b1;
  endfunction

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_comb begin
    wp_d  = do_push ? ptr_inc(wp_q) : wp_q;
    rp_d  = do_pop  ? ptr_inc(rp_q) : rp_q;
    cnt_d = cnt_q;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wp_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem_q[rp_q];
  assign count = cnt_q;

endmodule

// File: rtl/dsi_rsp_parse.sv
module dsi_rsp_parse
  import dsi_rsp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_first,
  input  logic        rx_last,
  input  logic        fifo_full,
  input  logic        udf_evt,
  output logic        push,
  output logic [31:0] push_word,
  output logic [1:0]  trig_kind,
  output logic [15:0] err_rpt,
  output logic        ecc_fixed,
  output logic        ecc_multi,
  output logic        proto_err,
  output logic        ovf,
  output logic        udf
);

  pst_e             st_q, st_d;
  logic [2:0][7:0]  hb_q, hb_d;
  logic [1:0]       idx_q, idx_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic [23:0]      acc_q, acc_d;
  logic [1:0]       bidx_q, bidx_d;
  trig_e            trig_q, trig_d;
  logic [15:0]      err_q, err_d;
  logic [4:0]       flg_q, flg_d;   // {udf, ovf, proto, multi, fixed}

  logic [23:0]      hdr_fix;
  logic             ecc_single, ecc_bad;
  logic [31:0]      w32;
  logic             clr, set_proto, set_fixed, set_multi;

  dsi_rsp_ecc i_ecc (
    .data_in    (hb_q),
    .ecc_in     (rx_byte),
    .data_out   (hdr_fix),
    .single_fix (ecc_single),
    .multi_err  (ecc_bad)
  );

  assign w32 = {8'h00, acc_q} | ({24'h0, rx_byte} << {bidx_q, 3'b000});
  assign clr = rx_valid && rx_first;

  always_comb begin
    st_d      = st_q;
    hb_d      = hb_q;
    idx_d     = idx_q;
    rem_d     = rem_q;
    acc_d     = acc_q;
    bidx_d    = bidx_q;
    trig_d    = trig_q;
    err_d     = clr ? 16'h0 : err_q;
    push      = 1'b0;
    push_word = 32'h0;
    set_proto = 1'b0;
    set_fixed = 1'b0;
    set_multi = 1'b0;
    if (rx_valid && rx_first) begin
      push      = 1'b1;
      push_word = {24'h0, rx_byte};
      idx_d     = 2'd0;
      case (rx_byte)
        TRIG_ACK_CODE: trig_d = TRIG_ACK;
        TRIG_ESC_CODE: trig_d = TRIG_ESC;
        default:       trig_d = TRIG_UNK;
      endcase
      if (rx_last)                       st_d = ST_IDLE;
      else if (rx_byte == TRIG_ACK_CODE) st_d = ST_HDR;
      else                               st_d = ST_DRAIN;
    end else if (rx_valid) begin
      case (st_q)
        ST_HDR: begin
          if (idx_q != 2'd3) begin
            hb_d[idx_q] = rx_byte;
            idx_d       = idx_q + 1'b1;
            if (rx_last) begin
              set_proto = 1'b1;
              st_d      = ST_IDLE;
            end
          end else if (ecc_bad) begin
            set_multi = 1'b1;
            st_d      = rx_last ? ST_IDLE : ST_DRAIN;
          end else begin
            set_fixed = ecc_single;
            st_d      = rx_last ? ST_IDLE : ST_DRAIN;
            case (hdr_fix[5:0])
              DT_ACK_ERR: begin
                push      = 1'b1;
                push_word = {8'h00, hdr_fix};
                err_d     = hdr_fix[23:8];
              end
              DT_SHORT1, DT_SHORT2: begin
                push      = 1'b1;
                push_word = {8'h00, hdr_fix};
              end
              DT_GEN_LONG, DT_DCS_LONG: begin
                push      = 1'b1;
                push_word = {8'h00, hdr_fix};
                rem_d     = hdr_fix[23:8];
                acc_d     = 24'h0;
                bidx_d    = 2'd0;
                idx_d     = 2'd0;
                if (rx_last) begin
                  set_proto = 1'b1;
                  st_d      = ST_IDLE;
                end else begin
                  st_d = (hdr_fix[23:8] == '0) ? ST_CSUM : ST_PAY;
                end
              end
              default: set_proto = 1'b1;
            endcase
          end
        end
        ST_PAY: begin
          rem_d = rem_q - 1'b1;
          if (bidx_q == 2'd3 || rem_q == LEN_W'(1)) begin
            push      = 1'b1;
            push_word = w32;
            acc_d     = 24'h0;
            bidx_d    = 2'd0;
          end else begin
            acc_d  = w32[23:0];
            bidx_d = bidx_q + 1'b1;
          end
          if (rem_q == LEN_W'(1)) begin
            st_d  = ST_CSUM;
            idx_d = 2'd0;
          end
          if (rx_last) begin
            set_proto = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_CSUM: begin
          idx_d = idx_q + 1'b1;
          if (idx_q == 2'd1) begin
            st_d = rx_last ? ST_IDLE : ST_DRAIN;
          end else if (rx_last) begin
            set_proto = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        ST_DRAIN: begin
          if (rx_last) st_d = ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    flg_d    = clr ? 5'b0 : flg_q;
    flg_d[0] = flg_d[0] | set_fixed;
    flg_d[1] = flg_d[1] | set_multi;
    flg_d[2] = flg_d[2] | set_proto;
    flg_d[3] = flg_d[3] | (push && fifo_full);
    flg_d[4] = flg_d[4] | udf_evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      hb_q   <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      acc_q  <= '0;
      bidx_q <= '0;
      trig_q <= TRIG_NONE;
      err_q  <= '0;
      flg_q  <= '0;
    end else begin
      st_q   <= st_d;
      hb_q   <= hb_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      acc_q  <= acc_d;
      bidx_q <= bidx_d;
      trig_q <= trig_d;
      err_q  <= err_d;
      flg_q  <= flg_d;
    end
  end

  assign trig_kind = trig_q;
  assign err_rpt   = err_q;
  assign ecc_fixed = flg_q[0];
  assign ecc_multi = flg_q[1];
  assign proto_err = flg_q[2];
  assign ovf       = flg_q[3];
  assign udf       = flg_q[4];

endmodule

// File: rtl/dsi_rsp_parser.sv
module dsi_rsp_parser #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_valid,
  input  logic [7:0]       rx_byte,
  input  logic             rx_first,
  input  logic             rx_last,
  input  logic             rd_pop,
  output logic [31:0]      rd_data,
  output logic [CNT_W-1:0] rd_count,
  output logic [1:0]       trig_kind,
  output logic [15:0]      err_rpt,
  output logic             ecc_fixed,
  output logic             ecc_multi,
  output logic             proto_err,
  output logic             ovf,
  output logic             udf
);

  logic        word_push, fifo_push, fifo_full, fifo_empty, udf_evt;
  logic [31:0] word;

  assign fifo_push = word_push && !fifo_full;
  assign udf_evt   = rd_pop && fifo_empty;

  dsi_rsp_parse i_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_first  (rx_first),
    .rx_last   (rx_last),
    .fifo_full (fifo_full),
    .udf_evt   (udf_evt),
    .push      (word_push),
    .push_word (word),
    .trig_kind (trig_kind),
    .err_rpt   (err_rpt),
    .ecc_fixed (ecc_fixed),
    .ecc_multi (ecc_multi),
    .proto_err (proto_err),
    .ovf       (ovf),
    .udf       (udf)
  );

  dsi_rsp_fifo #(.W(32), .DEPTH(DEPTH)) i_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (fifo_push),
    .wdata (word),
    .pop   (rd_pop),
    .rdata (rd_data),
    .count (rd_count),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

endmodule

// File: rtl/dsi_rsp_parser_chk.sv
module dsi_rsp_parser_chk #(
  parameter int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_valid,
  input logic [7:0]       rx_byte,
  input logic             rx_first,
  input logic             rd_pop,
  input logic [31:0]      rd_data,
  input logic [CNT_W-1:0] rd_count,
  input logic             fifo_push,
  input logic [1:0]       trig_kind,
  input logic [15:0]      err_rpt,
  input logic             ecc_fixed,
  input logic             ecc_multi,
  input logic             proto_err,
  input logic             udf
);

  p_push_on_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> rx_valid);

  p_ack_kind_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first && rx_byte == 8'h84) |=> (trig_kind == 2'd1));

  p_pop_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_count != '0 && !fifo_push) |=> (rd_count == $past(rd_count) - CNT_W'(1)));

  p_empty_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_count == '0) |-> (rd_data == 32'h0));

  p_udf_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && rd_count == '0) |=> udf);

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_count <= CNT_W'(DEPTH));

  p_trig_clears_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_first) |=> (!ecc_fixed && !ecc_multi && !proto_err && err_rpt == 16'h0));

endmodule

bind dsi_rsp_parser dsi_rsp_parser_chk #(.DEPTH(DEPTH)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .rx_byte   (rx_byte),
  .rx_first  (rx_first),
  .rd_pop    (rd_pop),
  .rd_data   (rd_data),
  .rd_count  (rd_count),
  .fifo_push (fifo_push),
  .trig_kind (trig_kind),
  .err_rpt   (err_rpt),
  .ecc_fixed (ecc_fixed),
  .ecc_multi (ecc_multi),
  .proto_err (proto_err),
  .udf       (udf)
);

// File: tb/test_dsi_rsp_parser.sv
`timescale 1ns/1ps
module test_dsi_rsp_parser;

  localparam int DEPTH = 16;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_valid = 1'b0;
  logic [7:0]       rx_byte = 8'h00;
  logic             rx_first = 1'b0;
  logic             rx_last = 1'b0;
  logic             rd_pop = 1'b0;
  logic [31:0]      rd_data;
  logic [CNT_W-1:0] rd_count;
  logic [1:0]       trig_kind;
  logic [15:0]      err_rpt;
  logic             ecc_fixed, ecc_multi, proto_err, ovf, udf;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] q[$];

  always #2 clk = ~clk;

  dsi_rsp_parser #(.DEPTH(DEPTH)) i_dsi_rsp_parser (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_first(rx_first), .rx_last(rx_last), .rd_pop(rd_pop),
    .rd_data(rd_data), .rd_count(rd_count), .trig_kind(trig_kind),
    .err_rpt(err_rpt), .ecc_fixed(ecc_fixed), .ecc_multi(ecc_multi),
    .proto_err(proto_err), .ovf(ovf), .udf(udf)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Independent encoder from the six parity masks
  function automatic logic [7:0] ecc_of(input logic [23:0] d);
    logic [5:0] p;
    p[0] = ^(d & 24'hF12CB7);
    p[1] = ^(d & 24'hF2555B);
    p[2] = ^(d & 24'h749A6D);
    p[3] = ^(d & 24'hB8E38E);
    p[4] = ^(d & 24'hDF03F0);
    p[5] = ^(d & 24'hEFFC00);
    return {2'b00, p};
  endfunction

  task automatic add_hdr(input logic [7:0] di, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [23:0] flip);
    logic [23:0] d;
    logic [7:0]  e;
    d = {b1, b0, di};
    e = ecc_of(d);
    d = d ^ flip;
    q.push_back(d[7:0]);
    q.push_back(d[15:8]);
    q.push_back(d[23:16]);
    q.push_back(e);
  endtask

  task automatic send_q();
    for (int i = 0; i < q.size(); i++) begin
      rx_valid = 1'b1;
      rx_byte  = q[i];
      rx_first = (i == 0);
      rx_last  = (i == q.size() - 1);
      @(negedge clk);
    end
    rx_valid = 1'b0;
    rx_first = 1'b0;
    rx_last  = 1'b0;
    q.delete();
  endtask

  task automatic pop_word(input string req, input logic [31:0] exp);
    check(req, rd_data, exp);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 count", 32'(rd_count), 32'd0);
    check("R1 data", rd_data, 32'h0);
    check("R1 kind", 32'(trig_kind), 32'd0);
    check("R1 flags", {err_rpt, 11'h0, ecc_fixed, ecc_multi, proto_err, ovf, udf}, 32'h0);
  endtask

  task automatic t_triggers();
    q.push_back(8'h84);
    send_q();
    check("R2 ack kind", 32'(trig_kind), 32'd1);
    check("R2 ack count", 32'(rd_count), 32'd1);
    pop_word("R2 ack word", 32'h84);
    check("R9 count after pop", 32'(rd_count), 32'd0);
    q.push_back(8'h87); q.push_back(8'h21); q.push_back(8'h55); q.push_back(8'h66);
    send_q();
    check("R2 esc kind", 32'(trig_kind), 32'd2);
    check("R2 esc trailing ignored", 32'(rd_count), 32'd1);
    pop_word("R2 esc word", 32'h87);
    q.push_back(8'h3C);
    send_q();
    check("R2 unknown kind", 32'(trig_kind), 32'd3);
    pop_word("R2 unknown word", 32'h3C);
  endtask

  task automatic t_err_report();
    q.push_back(8'h84);
    add_hdr(8'h02, 8'h10, 8'h80, 24'h0);
    send_q();
    check("R3 count", 32'(rd_count), 32'd2);
    check("R3 err_rpt", 32'(err_rpt), 32'h8010);
    pop_word("R3 trigger", 32'h84);
    pop_word("R3 header", 32'h0080_1002);
    q.push_back(8'h84);
    send_q();
    check("R12 err_rpt cleared", 32'(err_rpt), 32'h0);
    pop_word("R12 trigger", 32'h84);
  endtask

  task automatic t_short();
    q.push_back(8'h84);
    add_hdr(8'h21, 8'hA5, 8'h00, 24'h0);
    send_q();
    check("R4 one byte count", 32'(rd_count), 32'd2);
    pop_word("R4 trigger", 32'h84);
    pop_word("R4 one byte word", 32'h0000_A521);
    q.push_back(8'h84);
    add_hdr(8'h22, 8'h34, 8'h12, 24'h0);
    send_q();
    pop_word("R4 trigger b", 32'h84);
    pop_word("R4 two byte word", 32'h0012_3422);
    check("R4 flags clean", {29'h0, ecc_fixed, ecc_multi, proto_err}, 32'h0);
  endtask

  task automatic t_long();
    q.push_back(8'h84);
    add_hdr(8'h1A, 8'h06, 8'h00, 24'h0);
    for (int i = 0; i < 6; i++) q.push_back(8'(8'h11 + i));
    q.push_back(8'hEE); q.push_back(8'hDD);
    send_q();
    check("R5 count partial", 32'(rd_count), 32'd4);
    check("R5 no proto", 32'(proto_err), 32'd0);
    pop_word("R5 trigger", 32'h84);
    pop_word("R5 header", 32'h0000_061A);
    pop_word("R5 word0", 32'h1413_1211);
    pop_word("R5 word1 padded", 32'h0000_1615);
    q.push_back(8'h84);
    add_hdr(8'h1C, 8'h04, 8'h00, 24'h0);
    q.push_back(8'hA1); q.push_back(8'hB2); q.push_back(8'hC3); q.push_back(8'hD4);
    q.push_back(8'h5A); q.push_back(8'h5B);
    send_q();
    check("R5 count exact", 32'(rd_count), 32'd3);
    pop_word("R5 trigger b", 32'h84);
    pop_word("R5 dcs header", 32'h0000_041C);
    pop_word("R5 dcs word", 32'hD4C3_B2A1);
    check("R5 checksum dropped", 32'(rd_count), 32'd0);
  endtask

  task automatic t_bad_type();
    q.push_back(8'h84);
    add_hdr(8'h05, 8'h01, 8'h02, 24'h0);
    send_q();
    check("R6 proto_err", 32'(proto_err), 32'd1);
    check("R6 no data", 32'(rd_count), 32'd1);
    pop_word("R6 trigger", 32'h84);
    q.push_back(8'h84);
    send_q();
    check("R12 proto cleared", 32'(proto_err), 32'd0);
    pop_word("R12 trigger b", 32'h84);
  endtask

  task automatic t_ecc();
    q.push_back(8'h84);
    add_hdr(8'h21, 8'h5A, 8'h00, 24'h00_0200);
    send_q();
    check("R7 ecc_fixed", 32'(ecc_fixed), 32'd1);
    pop_word("R7 trigger", 32'h84);
    pop_word("R7 corrected word", 32'h0000_5A21);
    q.push_back(8'h84);
    add_hdr(8'h21, 8'h5A, 8'h00, 24'h00_0003);
    send_q();
    check("R8 ecc_multi", 32'(ecc_multi), 32'd1);
    check("R8 nothing pushed", 32'(rd_count), 32'd1);
    check("R12 fixed cleared", 32'(ecc_fixed), 32'd0);
    pop_word("R8 trigger", 32'h84);
  endtask

  task automatic t_trunc();
    q.push_back(8'h84);
    add_hdr(8'h1A, 8'h08, 8'h00, 24'h0);
    q.push_back(8'h01); q.push_back(8'h02); q.push_back(8'h03);
    send_q();
    check("R13 proto_err", 32'(proto_err), 32'd1);
    check("R13 partial dropped", 32'(rd_count), 32'd2);
    pop_word("R13 trigger", 32'h84);
    pop_word("R13 header", 32'h0000_081A);
  endtask

  task automatic t_underflow();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    check("R10 udf", 32'(udf), 32'd1);
    check("R10 count", 32'(rd_count), 32'd0);
    check("R10 data", rd_data, 32'h0);
  endtask

  task automatic t_overflow();
    q.push_back(8'h84);
    add_hdr(8'h1A, 8'h50, 8'h00, 24'h0);
    for (int i = 0; i < 80; i++) q.push_back(8'(i));
    q.push_back(8'h00); q.push_back(8'h00);
    send_q();
    check("R11 count capped", 32'(rd_count), 32'(DEPTH));
    check("R11 ovf", 32'(ovf), 32'd1);
    check("R12 udf cleared", 32'(udf), 32'd0);
    pop_word("R11 trigger", 32'h84);
    pop_word("R11 header", 32'h0000_501A);
    pop_word("R11 first payload", 32'h0302_0100);
    for (int i = 0; i < DEPTH - 3; i++) begin
      rd_pop = 1'b1;
      @(negedge clk);
    end
    rd_pop = 1'b0;
    check("R9 drained", 32'(rd_count), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_triggers();
    t_err_report();
    t_short();
    t_long();
    t_bad_type();
    t_ecc();
    t_trunc();
    t_underflow();
    t_overflow();
    finish_run();
  end

endmodule